// File: doc/BRIEF.md
# Byte-Bus 16-Bit Timer with Dual Compare

This block is a 16-bit counter with two 16-bit compare registers. A CPU reaches all of them over an 8-bit register bus. A single temporary byte register sits between the bus and every 16-bit register, so that a CPU working one byte at a time still sees and sets whole 16-bit values atomically:

- For a write, the high byte is staged in the temporary register first. The low-byte write then commits all 16 bits in one edge.
- For a read, the low byte is read first. That access freezes the live high byte into the temporary register, and a later high-byte read returns it.

The counter advances on each cycle in which the external timer clock enable is high. A control bit selects the count mode:

- In plain mode the counter counts up and wraps.
- In triangle mode it counts up and down, turning around at both ends of its range.

Each compare channel raises an interrupt flag one cycle after the counter counts into its compare value. A CPU write that makes the counter equal to a compare value raises nothing. The CPU clears a flag by writing a one to its bit.

The bus is a plain register interface with no back-pressure. A write takes effect at the edge where `wr_en` is high. `rd_data` is combinational from `addr` and is valid while `rd_en` is high. The temporary-register side effect of a read happens at that same edge. `wr_en` and `rd_en` are not raised in the same cycle.

Top module: `bytebus_timer16`

## Requirements
- R1: After reset the counter, both compare registers, the temporary byte, the mode bit and both flags are zero.
- R2: A write to address 1 (counter high byte) changes only the temporary byte; the counter keeps its value.
- R3: A write to address 0 (counter low byte) loads the counter with {temporary byte, written byte} at that edge, taking priority over a timer tick in the same cycle.
- R4: A read of address 0 returns the live counter low byte and, at the same edge, copies the live counter high byte into the temporary byte.
- R5: A read of address 1 returns the temporary byte, not the live counter high byte.
- R6: Compare channel A sits at addresses 2 (low) and 3 (high), channel B at 4 (low) and 5 (high). A high-byte write only stages the byte; the low-byte write commits {temporary byte, written byte}. Compare bytes read back directly from the committed register.
- R7: The counter and both compare channels share one temporary byte, so a staged high byte is consumed by whichever low-byte write comes next, whatever register that is.
- R8: After a counter load, the counter advances on the next cycle with the tick high; with the tick low it holds.
- R9: With the mode bit (address 6, bit 0) at zero, each tick adds one and 0xFFFF wraps to 0x0000.
- R10: With the mode bit at one, the counter turns downward after reaching 0xFFFF and upward after reaching 0x0000.
- R11: A flag is set one cycle after the counter, by counting, takes its channel's compare value; a CPU load to that value sets no flag.
- R12: Writing address 7 clears flag A where bit 0 is one and flag B where bit 1 is one; zero bits leave a flag alone. A set and a clear in the same cycle leave the flag set.
- R13: `cmp_irq` bit 0 is flag A and bit 1 is flag B, and reading address 7 returns the flags in those bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; counter advances when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte (combinational) |
| cmp_irq | output | 2 | Compare interrupt flags, bit 0 channel A, bit 1 channel B |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a flag set and the CPU's write-one clear. The bench counts the counter into compare A so that the set edge is exactly the edge carrying the clear write, and it expects the flag to stay high.

The second pair is a counter load and a timer tick. The bench holds the tick high through the low-byte write. It then expects the loaded value rather than an incremented one, followed by a single increment on the next ticking edge.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned CNT_LO_IDX = 0;
  localparam int unsigned CNT_HI_IDX = 1;
  localparam int unsigned CMP_BASE   = 2;

  function automatic int unsigned ctrl_idx(input int unsigned n_cmp);
    return CMP_BASE + 2 * n_cmp;
  endfunction
endpackage

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             stepped
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, nxt;
  logic dir_up_q, nxt_up, stepped_q;

  always_comb begin
    nxt    = cnt_q + ONE;
    nxt_up = 1'b1;
    if (mode) begin
      if (dir_up_q) begin
        if (cnt_q == MAXV) begin
          nxt    = cnt_q - ONE;
          nxt_up = 1'b0;
        end
      end else if (cnt_q != '0) begin
        nxt    = cnt_q - ONE;
        nxt_up = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      dir_up_q  <= 1'b1;
      stepped_q <= 1'b0;
    end else if (load) begin
      cnt_q     <= load_val;
      stepped_q <= 1'b0;
      if (!mode) dir_up_q <= 1'b1;
    end else if (tick) begin
      cnt_q     <= nxt;
      dir_up_q  <= nxt_up;
      stepped_q <= 1'b1;
    end else begin
      stepped_q <= 1'b0;
      if (!mode) dir_up_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign stepped = stepped_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  p_unit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (CNT_W'(cnt_q - $past(cnt_q)) == ONE ||
                         CNT_W'($past(cnt_q) - cnt_q) == ONE));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && tick && !load && cnt_q == MAXV) |=> (cnt_q == '0));
  p_turn_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && tick && !load && cnt_q == MAXV) |=> (cnt_q == MAXV - ONE));
endmodule

// File: rtl/tmr16_match.sv
module tmr16_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             stepped,
  input  logic             clr,
  output logic             flag
);
  logic flag_q, hit;

  assign hit = stepped && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  assign flag = flag_q;

  p_set_needs_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(stepped));
  p_set_beats_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q);
endmodule

// File: rtl/tmr16_bus.sv
module tmr16_bus
  import tmr16_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 16,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [BUS_W-1:0]               wr_data,
  output logic [BUS_W-1:0]               rd_data,
  input  logic [CNT_W-1:0]               cnt,
  input  logic [NUM_CMP-1:0]             flags,
  output logic                           cnt_load,
  output logic [CNT_W-1:0]               cnt_load_val,
  output logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_val,
  output logic                           mode,
  output logic [NUM_CMP-1:0]             flag_clr
);
  localparam int unsigned CTRL_A = ctrl_idx(NUM_CMP);
  localparam int unsigned FLAG_A = CTRL_A + 1;

  logic [BUS_W-1:0] temp_q;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= '0;
      cmp_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(CNT_HI_IDX)) temp_q <= wr_data;
      if (addr == ADDR_W'(CTRL_A))     mode_q <= wr_data[0];
      for (int k = 0; k < NUM_CMP; k++) begin
        if (addr == ADDR_W'(CMP_BASE + 2 * k + 1)) temp_q   <= wr_data;
        if (addr == ADDR_W'(CMP_BASE + 2 * k))     cmp_q[k] <= {temp_q, wr_data};
      end
    end else if (rd_en && addr == ADDR_W'(CNT_LO_IDX)) begin
      temp_q <= cnt[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CNT_LO_IDX)) rd_data = cnt[BUS_W-1:0];
    if (addr == ADDR_W'(CNT_HI_IDX)) rd_data = temp_q;
    if (addr == ADDR_W'(CTRL_A))     rd_data = BUS_W'(mode_q);
    if (addr == ADDR_W'(FLAG_A))     rd_data = BUS_W'(flags);
    for (int k = 0; k < NUM_CMP; k++) begin
      if (addr == ADDR_W'(CMP_BASE + 2 * k))     rd_data = cmp_q[k][BUS_W-1:0];
      if (addr == ADDR_W'(CMP_BASE + 2 * k + 1)) rd_data = cmp_q[k][CNT_W-1:BUS_W];
    end
  end

  assign cnt_load     = wr_en && (addr == ADDR_W'(CNT_LO_IDX));
  assign cnt_load_val = {temp_q, wr_data};
  assign cmp_val      = cmp_q;
  assign mode         = mode_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_clr
    assign flag_clr[g] = wr_en && (addr == ADDR_W'(FLAG_A)) && wr_data[g];
  end

  p_lo_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CNT_LO_IDX)) |=> (cnt == {$past(temp_q), $past(wr_data)}));
  p_lo_read_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == ADDR_W'(CNT_LO_IDX)) |=> (temp_q == $past(cnt[CNT_W-1:BUS_W])));
  p_cmp_hi_staged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CMP_BASE + 1)) |=> $stable(cmp_q));
endmodule

// File: rtl/bytebus_timer16.sv
module bytebus_timer16
  import tmr16_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int NUM_CMP = 2,
  parameter int ADDR_W  = $clog2(2 * NUM_CMP + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [BUS_W-1:0]   rd_data,
  output logic [NUM_CMP-1:0] cmp_irq
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt, load_val;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
  logic [NUM_CMP-1:0] flags, flag_clr;
  logic load, mode, stepped;

  tmr16_bus #(.BUS_W(BUS_W), .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cnt(cnt), .flags(flags),
    .cnt_load(load), .cnt_load_val(load_val), .cmp_val(cmp_val),
    .mode(mode), .flag_clr(flag_clr));

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .load(load),
    .load_val(load_val), .cnt(cnt), .stepped(stepped));

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_ch
    tmr16_match #(.CNT_W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp_val[g]),
      .stepped(stepped), .clr(flag_clr[g]), .flag(flags[g]));
  end

  assign cmp_irq = flags;

  p_hi_write_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CNT_HI_IDX) && !tick) |=> $stable(cnt));
  p_load_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && flags == '0) |=> ##1 (flags == '0));
endmodule

// File: tb/tb_bytebus_timer16.sv
module tb_bytebus_timer16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cmp_irq;
  int n_tests = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bytebus_timer16 dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cmp_irq(cmp_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd0, lo); rd(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(3'd1, v[15:8]); wr(3'd0, v[7:0]);
  endtask

  task automatic step(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v; logic [7:0] b;
    rd16(v);      check("R1 counter", v, 16'h0);
    rd(3'd2, b);  check("R1 cmpA lo", b, 8'h0);
    rd(3'd5, b);  check("R1 cmpB hi", b, 8'h0);
    rd(3'd6, b);  check("R1 mode", b, 8'h0);
    rd(3'd7, b);  check("R1 flags", b, 8'h0);
    check("R1 irq", cmp_irq, 2'b00);
  endtask

  task automatic t_hi_write;
    logic [15:0] v;
    wr(3'd1, 8'h7A);
    rd16(v); check("R2 hi write leaves counter", v, 16'h0000);
  endtask

  task automatic t_preset;
    logic [15:0] v;
    wr(3'd1, 8'h01);
    tick = 1'b1; wr(3'd0, 8'h00); tick = 1'b0;
    rd16(v); check("R3 load beats tick", v, 16'h0100);
    wr(3'd1, 8'h01);
    tick = 1'b1; wr(3'd0, 8'h00);
    @(posedge clk); @(negedge clk); tick = 1'b0;
    rd16(v); check("R8 resume after preset", v, 16'h0101);
  endtask

  task automatic t_read_latch;
    logic [7:0] lo, hi;
    wr16(16'h12FF);
    rd(3'd0, lo); check("R4 live low byte", lo, 8'hFF);
    step(1);
    rd(3'd1, hi); check("R5 high from temp", hi, 8'h12);
    rd(3'd0, lo); check("R4 low after step", lo, 8'h00);
    rd(3'd1, hi); check("R4 temp recaptured", hi, 8'h13);
  endtask

  task automatic t_cmp_stage;
    logic [7:0] b;
    wr(3'd3, 8'h34);
    rd(3'd3, b); check("R6 hi only staged", b, 8'h00);
    wr(3'd2, 8'h56);
    rd(3'd3, b); check("R6 cmpA hi commit", b, 8'h34);
    rd(3'd2, b); check("R6 cmpA lo commit", b, 8'h56);
  endtask

  task automatic t_shared;
    logic [15:0] v; logic [7:0] b;
    wr(3'd1, 8'hAA); wr(3'd3, 8'h55); wr(3'd0, 8'h01);
    rd16(v); check("R7 counter takes latest staged byte", v, 16'h5501);
    wr(3'd5, 8'hC3); rd(3'd0, b); wr(3'd4, 8'h02);
    rd(3'd5, b); check("R7 read of counter low overwrote staged byte", b, 8'h55);
  endtask

  task automatic t_up_wrap;
    logic [15:0] v;
    wr16(16'hFFFE); step(1);
    rd16(v); check("R9 count up", v, 16'hFFFF);
    step(1);
    rd16(v); check("R9 wrap", v, 16'h0000);
  endtask

  task automatic t_updown;
    logic [15:0] v;
    wr(3'd6, 8'h01);
    wr16(16'hFFFE); step(1);
    rd16(v); check("R10 reach top", v, 16'hFFFF);
    step(2);
    rd16(v); check("R10 turn down", v, 16'hFFFD);
    wr16(16'h0001); step(3);
    rd16(v); check("R10 turn up at zero", v, 16'h0002);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_match;
    logic [7:0] b;
    wr(3'd7, 8'h03);
    wr(3'd3, 8'h00); wr(3'd2, 8'h10);
    wr(3'd5, 8'h00); wr(3'd4, 8'h20);
    wr16(16'h000E);
    step(2);
    check("R11 no flag in match cycle", cmp_irq, 2'b00);
    @(posedge clk); @(negedge clk);
    check("R11 flag one cycle later", cmp_irq, 2'b01);
    rd(3'd7, b); check("R13 flag register", b, 8'h01);
    wr16(16'h0020);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 software equality no flag", cmp_irq, 2'b01);
  endtask

  task automatic t_clear;
    wr(3'd7, 8'h00);
    check("R12 zero bit keeps flag", cmp_irq, 2'b01);
    wr(3'd7, 8'h01);
    check("R12 write one clears", cmp_irq, 2'b00);
    wr16(16'h000F);
    step(1);
    wr(3'd7, 8'h01);
    check("R12 set beats clear", cmp_irq, 2'b01);
    wr(3'd7, 8'h03);
    check("R13 irq after clear", cmp_irq, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset(); t_hi_write(); t_preset(); t_read_latch(); t_cmp_stage();
    t_shared(); t_up_wrap(); t_updown(); t_match(); t_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule